// File: doc/BRIEF.md
# Serial Link Self-Test Pattern Checker

This block sits on the receive side of a serial link and grades an at-speed self-test run. Received 10-bit words come with a valid flag. The block compares each one against a pseudo-random reference that it generates itself. The reference follows the sequence s[n] = s[n-14] xor s[n-15] (polynomial x^15 + x^14 + 1). The block sums the bit errors over a fixed number of graded words. When the run ends it raises a complete flag and a pass flag. Pass means the error count stayed at or below a small threshold. With the defaults this is a bit-error rate better than one in ten million over about 21 million bits.

The checker is armed with a one-cycle request. It may be armed long before the far end starts sending, and it waits for the first word with no timeout. A late-start flag records whether that first word arrived within the allowed window of system clocks after arming. The flag only informs and does not abort the run. The reference locks onto the stream by loading itself from the first received bits. After that it advances on its own expected bits, so one corrupted word costs only its own flipped bits.

Top module: `lbist_rx_checker`

## Requirements
- R1: After reset, done_o, pass_o and late_o are 0 and err_cnt_o is 0.
- R2: A cycle with arm_i high clears done_o, pass_o, late_o and err_cnt_o on the next clock and restarts the run, even in the middle of a run. A valid word presented in that same cycle is discarded.
- R3: After arming, the first SEED = ceil(15/WORD_W) valid words (2 at WORD_W=10) load the reference and are not graded. Bit 0 of each word is the earliest bit of the stream. The reference continues s[n] = s[n-14] xor s[n-15] from those bits.
- R4: Each later valid word adds to the error count the number of bit positions in which it differs from the reference. The reference advances by its own expected bits, so a corrupted word does not cause errors in the words after it.
- R5: The error count saturates at 2^ERR_W-1 and does not wrap.
- R6: done_o rises on the clock that samples the 2^RUN_LEN_LOG2-th graded word. Until the next arm, done_o, pass_o, late_o and err_cnt_o then hold, whatever words arrive.
- R7: pass_o rises together with done_o if and only if the final error count is at most MAX_ERR. pass_o is 0 whenever done_o is 0.
- R8: Cycles with rx_valid_i low are ignored, both before the first word and between words. The wait for the first word has no time limit.
- R9: Let the arm request be sampled at clock k and the first valid word at clock k+d. late_o is set if d > START_WIN and stays clear if d <= START_WIN.
- R10: Before the first arm after reset, valid words are ignored and all outputs stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Arm request; clears status and restarts the run |
| rx_valid_i | input | 1 | Received word is valid this cycle |
| rx_word_i | input | WORD_W | Received word, bit 0 earliest on the line |
| done_o | output | 1 | Run complete |
| pass_o | output | 1 | Run passed the error threshold |
| late_o | output | 1 | First word arrived after the start window |
| err_cnt_o | output | ERR_W | Saturating bit-error count |

## Verification
A reference generator that is misaligned or has a wrong tap produces errors on nearly every graded word. err_cnt_o therefore climbs, or saturates, from the clock after the first graded word. A wrong word counter moves the done_o edge away from the clock that samples the last word, and the edge is checked on the negedge right after it. A start-window counter that is off by one flips late_o only at the boundary delays START_WIN and START_WIN+1, so the run sweeps the arm-to-first-word delay across that boundary.

// File: rtl/lbist_rx_pkg.sv
package lbist_rx_pkg;
  localparam int PRBS_LEN   = 15;
  localparam int PRBS_TAP_A = 14;
  localparam int PRBS_TAP_B = 15;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEED = 2'd1,
    ST_RUN  = 2'd2,
    ST_DONE = 2'd3
  } chk_state_e;
endpackage

// File: rtl/lbist_prbs_ref.sv
module lbist_prbs_ref
  import lbist_rx_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              seed_en_i,
  input  logic              step_en_i,
  input  logic [WORD_W-1:0] rx_word_i,
  output logic [WORD_W-1:0] exp_word_o
);
  // hist_q[0] is the most recent stream bit
  logic [PRBS_LEN-1:0] hist_q, hist_seed, hist_step;
  logic [WORD_W-1:0]   exp_word;

  always_comb begin
    hist_seed = hist_q;
    for (int j = 0; j < WORD_W; j++) begin
      hist_seed = {hist_seed[PRBS_LEN-2:0], rx_word_i[j]};
    end
    hist_step = hist_q;
    exp_word  = '0;
    for (int j = 0; j < WORD_W; j++) begin
      exp_word[j] = hist_step[PRBS_TAP_A-1] ^ hist_step[PRBS_TAP_B-1];
      hist_step   = {hist_step[PRBS_LEN-2:0], exp_word[j]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hist_q <= '0;
    else if (seed_en_i) hist_q <= hist_seed;
    else if (step_en_i) hist_q <= hist_step;
  end

  assign exp_word_o = exp_word;
endmodule

// File: rtl/lbist_err_accum.sv
module lbist_err_accum #(
  parameter int WORD_W = 10,
  parameter int ERR_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic [WORD_W-1:0] rx_word_i,
  input  logic [WORD_W-1:0] exp_word_i,
  output logic [ERR_W-1:0]  cnt_o,
  output logic [ERR_W-1:0]  cnt_next_o
);
  localparam int POP_W = $clog2(WORD_W + 1);
  localparam int SUM_W = ((ERR_W > POP_W) ? ERR_W : POP_W) + 1;
  localparam logic [ERR_W-1:0] CNT_MAX = {ERR_W{1'b1}};

  logic [WORD_W-1:0] diff;
  logic [POP_W-1:0]  pop;
  logic [SUM_W-1:0]  sum;
  logic [ERR_W-1:0]  cnt_q, cnt_d;

  always_comb begin
    diff = rx_word_i ^ exp_word_i;
    pop  = '0;
    for (int j = 0; j < WORD_W; j++) pop = pop + POP_W'(diff[j]);
    sum = SUM_W'(cnt_q) + SUM_W'(pop);
    if (!en_i)                      cnt_d = cnt_q;
    else if (sum > SUM_W'(CNT_MAX)) cnt_d = CNT_MAX;
    else                            cnt_d = sum[ERR_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_d;
  end

  assign cnt_o      = cnt_q;
  assign cnt_next_o = cnt_d;
endmodule

// File: rtl/lbist_start_mon.sv
module lbist_start_mon #(
  parameter int START_WIN = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic waiting_i,
  input  logic first_i,
  output logic late_o
);
  localparam int CNT_W = $clog2(START_WIN + 1);
  localparam logic [CNT_W-1:0] WIN = CNT_W'(START_WIN);

  logic [CNT_W-1:0] cnt_q;
  logic             late_q;

  // cnt_q equals clocks elapsed since arm minus one, saturating at WIN
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      late_q <= 1'b0;
    end else if (arm_i) begin
      cnt_q  <= '0;
      late_q <= 1'b0;
    end else if (first_i) begin
      late_q <= (cnt_q >= WIN);
    end else if (waiting_i && cnt_q != WIN) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign late_o = late_q;
endmodule

// File: rtl/lbist_run_ctrl.sv
module lbist_run_ctrl
  import lbist_rx_pkg::*;
#(
  parameter int WORD_W       = 10,
  parameter int RUN_LEN_LOG2 = 21,
  parameter int ERR_W        = 8,
  parameter int MAX_ERR      = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             rx_valid_i,
  input  logic [ERR_W-1:0] err_next_i,
  output logic             seed_en_o,
  output logic             step_en_o,
  output logic             first_o,
  output logic             waiting_o,
  output logic             done_o,
  output logic             pass_o
);
  localparam int SEED_WORDS = (PRBS_LEN + WORD_W - 1) / WORD_W;
  localparam int SIDX_W     = (SEED_WORDS > 1) ? $clog2(SEED_WORDS) : 1;
  localparam logic [SIDX_W-1:0]       SEED_LAST = SIDX_W'(SEED_WORDS - 1);
  localparam logic [RUN_LEN_LOG2-1:0] RUN_LAST  = {RUN_LEN_LOG2{1'b1}};

  chk_state_e              state_q;
  logic [SIDX_W-1:0]       sidx_q;
  logic [RUN_LEN_LOG2-1:0] wcnt_q;
  logic                    done_q, pass_q;

  assign seed_en_o = !arm_i && rx_valid_i && (state_q == ST_SEED);
  assign step_en_o = !arm_i && rx_valid_i && (state_q == ST_RUN);
  assign waiting_o = (state_q == ST_SEED) && (sidx_q == '0);
  assign first_o   = seed_en_o && (sidx_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sidx_q  <= '0;
      wcnt_q  <= '0;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
    end else if (arm_i) begin
      state_q <= ST_SEED;
      sidx_q  <= '0;
      wcnt_q  <= '0;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_SEED: if (rx_valid_i) begin
          if (sidx_q == SEED_LAST) state_q <= ST_RUN;
          else                     sidx_q  <= sidx_q + 1'b1;
        end
        ST_RUN: if (rx_valid_i) begin
          if (wcnt_q == RUN_LAST) begin
            state_q <= ST_DONE;
            done_q  <= 1'b1;
            pass_q  <= (err_next_i <= ERR_W'(MAX_ERR));
          end else begin
            wcnt_q <= wcnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign done_o = done_q;
  assign pass_o = pass_q;
endmodule

// File: rtl/lbist_rx_checker.sv
module lbist_rx_checker #(
  parameter int WORD_W       = 10,
  parameter int RUN_LEN_LOG2 = 21,
  parameter int START_WIN    = 4096,
  parameter int MAX_ERR      = 2,
  parameter int ERR_W        = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              rx_valid_i,
  input  logic [WORD_W-1:0] rx_word_i,
  output logic              done_o,
  output logic              pass_o,
  output logic              late_o,
  output logic [ERR_W-1:0]  err_cnt_o
);
  logic              seed_en, step_en, first, waiting;
  logic [WORD_W-1:0] exp_word;
  logic [ERR_W-1:0]  err_next;

  lbist_run_ctrl #(
    .WORD_W(WORD_W), .RUN_LEN_LOG2(RUN_LEN_LOG2), .ERR_W(ERR_W), .MAX_ERR(MAX_ERR)
  ) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .arm_i(arm_i), .rx_valid_i(rx_valid_i),
    .err_next_i(err_next), .seed_en_o(seed_en), .step_en_o(step_en),
    .first_o(first), .waiting_o(waiting), .done_o(done_o), .pass_o(pass_o)
  );

  lbist_prbs_ref #(.WORD_W(WORD_W)) u_ref (
    .clk_i(clk_i), .rst_ni(rst_ni), .seed_en_i(seed_en), .step_en_i(step_en),
    .rx_word_i(rx_word_i), .exp_word_o(exp_word)
  );

  lbist_err_accum #(.WORD_W(WORD_W), .ERR_W(ERR_W)) u_err (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(arm_i), .en_i(step_en),
    .rx_word_i(rx_word_i), .exp_word_i(exp_word),
    .cnt_o(err_cnt_o), .cnt_next_o(err_next)
  );

  lbist_start_mon #(.START_WIN(START_WIN)) u_start (
    .clk_i(clk_i), .rst_ni(rst_ni), .arm_i(arm_i), .waiting_i(waiting),
    .first_i(first), .late_o(late_o)
  );
endmodule

// File: rtl/lbist_rx_checker_sva.sv
module lbist_rx_checker_sva #(
  parameter int MAX_ERR = 2,
  parameter int ERR_W   = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             arm_i,
  input logic             done_o,
  input logic             pass_o,
  input logic             late_o,
  input logic [ERR_W-1:0] err_cnt_o
);
  localparam logic [ERR_W-1:0] CNT_MAX = {ERR_W{1'b1}};

  p_arm_clears_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> (!done_o && !pass_o && !late_o && err_cnt_o == '0));

  p_err_monotonic_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i |=> (err_cnt_o >= $past(err_cnt_o)));

  p_err_saturates_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_cnt_o == CNT_MAX && !arm_i) |=> (err_cnt_o == CNT_MAX));

  p_done_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !arm_i) |=> (done_o && $stable(pass_o) && $stable(late_o) && $stable(err_cnt_o)));

  p_pass_needs_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |-> done_o);

  p_pass_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |-> (err_cnt_o <= ERR_W'(MAX_ERR)));

  p_late_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (late_o && !arm_i) |=> late_o);
endmodule

bind lbist_rx_checker lbist_rx_checker_sva #(.MAX_ERR(MAX_ERR), .ERR_W(ERR_W)) sva_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .arm_i(arm_i), .done_o(done_o),
  .pass_o(pass_o), .late_o(late_o), .err_cnt_o(err_cnt_o)
);

// File: tb/lbist_rx_checker_tb_top.sv
`timescale 1ns/1ps
module lbist_rx_checker_tb_top;
  localparam int WORD_W   = 10;
  localparam int RUN_LOG2 = 5;
  localparam int RUN_LEN  = 1 << RUN_LOG2;
  localparam int WIN      = 16;
  localparam int MAXE     = 2;
  localparam int ERRW     = 4;
  localparam int SATV     = (1 << ERRW) - 1;
  localparam int SEEDW    = 2;
  localparam int NBITS    = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm = 1'b0;
  logic rx_valid = 1'b0;
  logic [WORD_W-1:0] rx_word = '0;
  logic done, pass, late;
  logic [ERRW-1:0] err_cnt;

  int n_checks = 0;
  int n_fail = 0;
  logic sbit [NBITS];

  always #2.5 clk = ~clk;

  lbist_rx_checker #(
    .WORD_W(WORD_W), .RUN_LEN_LOG2(RUN_LOG2), .START_WIN(WIN), .MAX_ERR(MAXE), .ERR_W(ERRW)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .arm_i(arm), .rx_valid_i(rx_valid), .rx_word_i(rx_word),
    .done_o(done), .pass_o(pass), .late_o(late), .err_cnt_o(err_cnt)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [WORD_W-1:0] get_word(input int w);
    logic [WORD_W-1:0] r;
    for (int j = 0; j < WORD_W; j++) r[j] = sbit[w*WORD_W + j];
    return r;
  endfunction

  function automatic int popc(input logic [WORD_W-1:0] m);
    int c = 0;
    for (int j = 0; j < WORD_W; j++) c += int'(m[j]);
    return c;
  endfunction

  task automatic send_word(input logic [WORD_W-1:0] w, input int gap);
    rx_valid = 1'b1;
    rx_word  = w;
    @(negedge clk);
    rx_valid = 1'b0;
    rx_word  = '0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic arm_pulse(input bit with_junk);
    arm = 1'b1;
    if (with_junk) begin
      rx_valid = 1'b1;
      rx_word  = 10'h2A5;
    end
    @(negedge clk);
    arm = 1'b0;
    rx_valid = 1'b0;
    rx_word  = '0;
  endtask

  // full run; checks at the negedge after the clock that samples the last word
  task automatic do_run(input int off, input int dly, input int gap, input int nerr_words,
                        input logic [WORD_W-1:0] mask, input bit junk_on_arm);
    int raw;
    int exp_err;
    arm_pulse(junk_on_arm);
    repeat (dly - 1) @(negedge clk);
    for (int i = 0; i < SEEDW; i++) send_word(get_word(off + i), gap);
    for (int g = 0; g < RUN_LEN; g++) begin
      logic [WORD_W-1:0] w;
      w = get_word(off + SEEDW + g);
      if (g < nerr_words) w = w ^ mask;
      send_word(w, (g == RUN_LEN - 1) ? 0 : gap);
    end
    raw = nerr_words * popc(mask);
    exp_err = (raw > SATV) ? SATV : raw;
    chk("R6 done at last word", int'(done), 1);
    chk("R4 error count", int'(err_cnt), exp_err);
    chk("R7 pass", int'(pass), (raw <= MAXE) ? 1 : 0);
    chk("R9 late flag", int'(late), (dly > WIN) ? 1 : 0);
  endtask

  initial begin
    repeat (120000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 15; i++) sbit[i] = 1'b1;
    for (int n = 15; n < NBITS; n++) sbit[n] = sbit[n-14] ^ sbit[n-15];

    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 done", int'(done), 0);
    chk("R1 pass", int'(pass), 0);
    chk("R1 late", int'(late), 0);
    chk("R1 err", int'(err_cnt), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: words before any arm are ignored
    for (int i = 0; i < 40; i++) send_word(get_word(i) ^ 10'h155, 0);
    chk("R10 idle done", int'(done), 0);
    chk("R10 idle err", int'(err_cnt), 0);
    chk("R10 idle late", int'(late), 0);

    // R3/R4/R7: sweep stream offsets, error word counts and masks
    for (int off = 0; off < 4; off++) begin
      for (int ne = 0; ne < 5; ne++) begin
        do_run(off * 7, 1, 0, ne, 10'h001 << off, 1'b0);
      end
    end
    do_run(11, 1, 0, 1, 10'h003, 1'b0);
    do_run(12, 1, 0, 1, 10'h007, 1'b0);
    do_run(13, 1, 0, 1, 10'h201, 1'b0);

    // R9: start-window boundary; R8: long wait with no timeout
    do_run(20, WIN - 1, 0, 0, '0, 1'b0);
    do_run(21, WIN, 0, 0, '0, 1'b0);
    do_run(22, WIN + 1, 0, 0, '0, 1'b0);
    do_run(23, WIN + 40, 0, 2, 10'h010, 1'b0);
    do_run(24, 3000, 0, 0, '0, 1'b0);

    // R8: gaps between words
    do_run(25, 3, 1, 2, 10'h100, 1'b0);
    do_run(26, 5, 3, 3, 10'h040, 1'b0);

    // R5: saturation
    do_run(27, 30, 0, 5, 10'h3FF, 1'b0);
    chk("R5 saturated", int'(err_cnt), SATV);

    // R6: hold after completion
    for (int i = 0; i < 10; i++) send_word(10'h3FF, 0);
    chk("R6 hold done", int'(done), 1);
    chk("R6 hold err", int'(err_cnt), SATV);
    chk("R6 hold pass", int'(pass), 0);
    chk("R6 hold late", int'(late), 1);

    // R2: arm clears everything
    arm_pulse(1'b0);
    chk("R2 clear done", int'(done), 0);
    chk("R2 clear err", int'(err_cnt), 0);
    chk("R2 clear late", int'(late), 0);
    chk("R2 clear pass", int'(pass), 0);
    repeat (4) @(negedge clk);

    // R2: word presented with arm is discarded
    do_run(30, 1, 0, 0, '0, 1'b1);

    // R2: re-arm in the middle of a run restarts it
    arm_pulse(1'b0);
    for (int i = 0; i < SEEDW + 10; i++) send_word(get_word(35 + i) ^ 10'h0F0, 0);
    chk("R2 mid-run errors seen", int'(err_cnt), SATV);
    do_run(40, 2, 0, 0, '0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule